// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block is a processor-controlled master for a three-wire serial memory link. It drives a clock line and shares one data line with an external serial EEPROM. The data line is split into an output level, an output enable and an input level, and a pad outside the block combines them. The processor first loads the data register. It then writes a control byte, which sets the number of clock pulses (0 to 8), the direction, whether the data line is released after a write, and whether the master then waits for the device to report ready. The block raises a busy level during the transfer and a one-cycle done pulse at the end. After a read, the data register holds the received bits.

The controller is one state machine with four states. `ST_IDLE` accepts control and data writes. `ST_LOW` and `ST_HIGH` are the two halves of each clock pulse, and each lasts `half_div+1` system clocks. `ST_WAIT` watches the released line for the ready level and counts toward a timeout. The transitions are:
- IDLE→LOW on an accepted control byte with a nonzero count.
- LOW→HIGH when the half period expires.
- HIGH→LOW when the half period expires and bits remain.
- HIGH→IDLE after the last bit when no wait is requested.
- HIGH→WAIT after the last bit of a write with both release and wait-ready set.
- WAIT→IDLE when the line reads high or when the timeout expires.

Top module: `ee3w_master`

## Requirements
- R1: Control byte layout: bits [3:0] hold the pulse count, bit 4 selects read (1) or write (0), bit 5 requests release of the data line after a write, and bit 6 requests the ready wait. `ctl_we` is accepted only while `xfer_busy` is low.
- R2: `ser_clk` idles low. An accepted transfer with count N produces exactly N pulses. Each half period is `half_div+1` clocks, sampled at acceptance. The first rising edge comes `half_div+1` clocks after the accepting edge.
- R3: On a read, `ser_din` is sampled at each rising edge of `ser_clk`. The data register shifts left and takes the sample as its LSB, so the first bit ends in the most significant position. After 8 bits `rdata` equals the received byte, valid in the cycle `xfer_busy` falls.
- R4: On a write, `ser_doe` is high from the accepting edge. `ser_dout` presents bit 7 of the data register first and moves to the next bit at each falling edge of `ser_clk`. After the last falling edge the line is held low when the release bit is 0 and released when it is 1. `ser_dout` is 0 whenever `ser_doe` is 0. A read never drives the line.
- R5: `xfer_busy` rises at the accepting edge. It falls at the edge of the last falling `ser_clk`, or at the end of the wait phase.
- R6: `xfer_done` is a one-cycle pulse, in the cycle `xfer_busy` falls, for every transfer with a nonzero count.
- R7: A control byte with count 0 produces no clock pulse, no busy and no done pulse. Only the release bit takes effect: 0 drives the line low, 1 releases it. The read bit is ignored.
- R8: A write with release and wait-ready both set enters a wait phase after its last falling edge, with the line released. It completes at the first clock edge that sees `ser_din` high. The wait bit has no effect on reads or on writes without release.
- R9: If `ser_din` stays low for `TMO_CYC` clocks of the wait phase, the transfer ends with a done pulse and `rdy_tmo_err` set. The flag clears at the next accepted control byte.
- R10: `ctl_we` and `data_we` while `xfer_busy` is high are ignored, and the running transfer continues unchanged.
- R11: Counts from 9 to 15 act as 8.
- R12: `data_we` while idle, and without `ctl_we` in the same cycle, loads `data_in`, which is visible on `rdata` in the following cycle.
- R13: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte (count, read, release, wait-ready) |
| data_we | input | 1 | Data register load strobe |
| data_in | input | DATA_W | Value loaded into the data register |
| half_div | input | DIV_W | Half period of ser_clk minus one, in clocks |
| ser_din | input | 1 | Level seen on the shared data line |
| ser_clk | output | 1 | Serial clock toward the device |
| ser_dout | output | 1 | Level driven on the data line |
| ser_doe | output | 1 | Drive enable for the data line |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data register contents |
| rdy_tmo_err | output | 1 | The last ready wait timed out |

## Verification
Every output is a register, so each result shows up in the cycle after the edge that causes it. With h = `half_div+1` and the accepting edge as cycle 0:
- Busy and the first data bit appear at cycle 0.
- Rising edges of `ser_clk` fall at odd multiples of h.
- The last falling edge, the end of busy and the done pulse come at cycle 2·N·h, plus the wait length when a ready wait is used.
- A ready level is acted on one cycle after the bench raises it.

The reference model in the bench derives every expected output from the cycles elapsed since acceptance. It compares the outputs at each falling clock edge, half a period away from the edge where the design updates, so every comparison falls in the cycle the result is due.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_WAIT = 2'd3
    } ee3w_state_e;

    typedef struct packed {
        logic       wrdy;
        logic       rel;
        logic       rd;
        logic [3:0] cnt;
    } ee3w_ctl_t;

    // Field split of the control byte; the count is limited to the register width.
    function automatic ee3w_ctl_t ee3w_decode(input logic [7:0] b, input logic [3:0] max_bits);
        ee3w_ctl_t c;
        c.cnt  = (b[3:0] > max_bits) ? max_bits : b[3:0];
        c.rd   = b[4];
        c.rel  = b[5];
        c.wrdy = b[6];
        return c;
    endfunction

endpackage

// File: rtl/ee3w_halfclk.sv
module ee3w_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ee3w_shreg.sv
module ee3w_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              fill,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[DATA_W-2:0], fill};
        end
    end
endmodule

// File: rtl/ee3w_rdywait.sv
module ee3w_rdywait #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic line_in,
    output logic ready,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign ready   = run && line_in;
    assign expired = run && !line_in && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ee3w_master.sv
module ee3w_master
    import ee3w_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DIV_W   = 8,
    parameter int TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_byte,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              ser_din,
    output logic              ser_clk,
    output logic              ser_dout,
    output logic              ser_doe,
    output logic              xfer_busy,
    output logic              xfer_done,
    output logic [DATA_W-1:0] rdata,
    output logic              rdy_tmo_err
);
    localparam logic [3:0] MAX_BITS = 4'(DATA_W);

    ee3w_state_e      state_q, state_d;
    ee3w_ctl_t        ctl_in, cfg_q;
    logic [3:0]       bits_q;
    logic [DIV_W-1:0] div_q;
    logic [DATA_W-1:0] sh_q;

    logic tick, last_bit, wait_eff, rdy_ok, tmo_hit;
    logic idle, accept, start, shift_en, load_en;

    assign ctl_in   = ee3w_decode(ctl_byte, MAX_BITS);
    assign idle     = (state_q == ST_IDLE);
    assign accept   = idle && ctl_we;
    assign start    = accept && (ctl_in.cnt != 4'd0);
    assign last_bit = (bits_q == 4'd1);
    assign wait_eff = cfg_q.wrdy && cfg_q.rel && !cfg_q.rd;
    assign load_en  = idle && data_we && !ctl_we;
    assign shift_en = tick && (((state_q == ST_LOW) && cfg_q.rd) ||
                               ((state_q == ST_HIGH) && !cfg_q.rd));

    ee3w_halfclk #(.DIV_W(DIV_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idle),
        .run   ((state_q == ST_LOW) || (state_q == ST_HIGH)),
        .div   (div_q),
        .tick  (tick)
    );

    ee3w_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (data_in),
        .shift    (shift_en),
        .fill     (cfg_q.rd && ser_din),
        .q        (sh_q)
    );

    ee3w_rdywait #(.TMO_CYC(TMO_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .line_in (ser_din),
        .ready   (rdy_ok),
        .expired (tmo_hit)
    );

    assign rdata = sh_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick) state_d = ST_HIGH;
            ST_HIGH: begin
                if (tick) begin
                    if (!last_bit)     state_d = ST_LOW;
                    else if (wait_eff) state_d = ST_WAIT;
                    else               state_d = ST_IDLE;
                end
            end
            ST_WAIT: if (rdy_ok || tmo_hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk     <= 1'b0;
            ser_dout    <= 1'b0;
            ser_doe     <= 1'b0;
            xfer_busy   <= 1'b0;
            xfer_done   <= 1'b0;
            rdy_tmo_err <= 1'b0;
            cfg_q       <= '0;
            bits_q      <= '0;
            div_q       <= '0;
        end else begin
            xfer_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rdy_tmo_err <= 1'b0;
                        if (ctl_in.cnt == 4'd0) begin
                            ser_doe  <= !ctl_in.rel;
                            ser_dout <= 1'b0;
                        end else begin
                            xfer_busy <= 1'b1;
                            cfg_q     <= ctl_in;
                            bits_q    <= ctl_in.cnt;
                            div_q     <= half_div;
                            ser_doe   <= !ctl_in.rd;
                            ser_dout  <= !ctl_in.rd && sh_q[DATA_W-1];
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) ser_clk <= 1'b1;
                end
                ST_HIGH: begin
                    if (tick) begin
                        ser_clk <= 1'b0;
                        bits_q  <= bits_q - 4'd1;
                        if (last_bit) begin
                            ser_dout <= 1'b0;
                            ser_doe  <= !cfg_q.rd && !cfg_q.rel;
                            if (!wait_eff) begin
                                xfer_busy <= 1'b0;
                                xfer_done <= 1'b1;
                            end
                        end else if (!cfg_q.rd) begin
                            ser_dout <= sh_q[DATA_W-2];
                        end
                    end
                end
                ST_WAIT: begin
                    if (rdy_ok) begin
                        xfer_busy <= 1'b0;
                        xfer_done <= 1'b1;
                    end else if (tmo_hit) begin
                        xfer_busy   <= 1'b0;
                        xfer_done   <= 1'b1;
                        rdy_tmo_err <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ee3w_master_chk.sv
module ee3w_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              data_we,
    input logic              ser_clk,
    input logic              ser_dout,
    input logic              ser_doe,
    input logic              xfer_busy,
    input logic              xfer_done,
    input logic [DATA_W-1:0] rdata,
    input logic              rdy_tmo_err
);
    a_r2_clk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> xfer_busy);

    a_r4_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_doe |-> !ser_dout);

    a_r5_busy_from_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(ctl_we));

    a_r6_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!xfer_busy && $past(xfer_busy)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_tmo_err) |-> xfer_done);

    a_r10_busy_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && ctl_we) |=> (xfer_busy || xfer_done));

    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && !$past(xfer_busy) && !$past(data_we)) |-> $stable(rdata));
endmodule

bind ee3w_master ee3w_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .data_we     (data_we),
    .ser_clk     (ser_clk),
    .ser_dout    (ser_dout),
    .ser_doe     (ser_doe),
    .xfer_busy   (xfer_busy),
    .xfer_done   (xfer_done),
    .rdata       (rdata),
    .rdy_tmo_err (rdy_tmo_err)
);

// File: tb/sim_ee3w_master.sv
`timescale 1ns/1ps
module sim_ee3w_master;
    localparam int DW   = 8;
    localparam int DIVW = 8;
    localparam int TMO  = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [7:0]    ctl_byte = '0;
    logic          data_we = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [DIVW-1:0] half_div = '0;
    logic          ser_din = 1'b0;
    logic          ser_clk, ser_dout, ser_doe, xfer_busy, xfer_done, rdy_tmo_err;
    logic [DW-1:0] rdata;

    ee3w_master #(.DATA_W(DW), .DIV_W(DIVW), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
        .data_we(data_we), .data_in(data_in), .half_div(half_div),
        .ser_din(ser_din), .ser_clk(ser_clk), .ser_dout(ser_dout),
        .ser_doe(ser_doe), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .rdata(rdata), .rdy_tmo_err(rdy_tmo_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int pulses   = 0;
    logic prev_clk = 1'b0;

    // Reference model: everything follows from cycles elapsed since acceptance.
    bit m_started, m_rd, m_rel, m_wf, m_ovr;
    int m_e = 0, m_n = 0, m_h = 1, m_rdy = 0, m_d = 0, m_ovr_val = 0, m_rbyte = 0;
    int tb_rbyte = 0, tb_rdy = 0;

    function automatic int f_min(input int a, input int b);
        return (a < b) ? a : b;
    endfunction
    function automatic int f_tend();
        return 2 * m_n * m_h;
    endfunction
    function automatic int f_done();
        return m_wf ? f_tend() + f_min(m_rdy + 1, TMO) : f_tend();
    endfunction
    function automatic int f_busy();
        return (m_started && m_e < f_done()) ? 1 : 0;
    endfunction
    function automatic int f_sclk();
        return (m_started && m_e < f_tend() && ((m_e / m_h) % 2 == 1)) ? 1 : 0;
    endfunction
    function automatic int f_irq();
        return (m_started && m_n > 0 && m_e == f_done()) ? 1 : 0;
    endfunction
    function automatic int f_oe();
        if (!m_started || m_rd) return 0;
        if (m_e < f_tend()) return 1;
        return m_rel ? 0 : 1;
    endfunction
    function automatic int f_sdo();
        if (f_oe() == 1 && m_e < f_tend()) return (m_d >> (7 - m_e / (2 * m_h))) & 1;
        return 0;
    endfunction
    function automatic int f_rdata();
        int r;
        if (m_ovr) return m_ovr_val;
        if (m_rd) begin
            r = f_min(m_n, (m_e + m_h) / (2 * m_h));
            return ((m_d << r) | (m_rbyte >> (8 - r))) & 255;
        end
        r = f_min(m_n, m_e / (2 * m_h));
        return (m_d << r) & 255;
    endfunction
    function automatic int f_err();
        return (m_started && m_wf && m_e >= f_done() && (m_rdy + 1 > TMO)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int cnt;
        if (!rst_n) begin
            m_started = 0; m_ovr = 1; m_ovr_val = 0; m_e = 0;
        end else if (ctl_we && f_busy() == 0) begin
            cnt = int'(ctl_byte[3:0]);
            if (cnt > 8) cnt = 8;
            m_d = f_rdata();
            m_ovr = 0; m_started = 1; m_e = 0; m_n = cnt;
            m_h = int'(half_div) + 1;
            m_rd  = (cnt != 0) && ctl_byte[4];
            m_rel = ctl_byte[5];
            m_wf  = (cnt != 0) && ctl_byte[6] && ctl_byte[5] && !ctl_byte[4];
            m_rbyte = tb_rbyte; m_rdy = tb_rdy;
        end else begin
            if (data_we && f_busy() == 0) begin
                m_ovr = 1; m_ovr_val = int'(data_in);
            end
            if (m_e < 1000000) m_e = m_e + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // Compare every cycle away from the active edge, then drive the device side.
    always @(negedge clk) begin
        int k;
        cycles++;
        if (!rst_n) begin
            chk("R13 ser_clk", int'(ser_clk), 0);
            chk("R13 xfer_busy", int'(xfer_busy), 0);
            chk("R13 ser_doe", int'(ser_doe), 0);
            chk("R13 rdata", int'(rdata), 0);
        end else begin
            chk("R2 ser_clk", int'(ser_clk), f_sclk());
            chk("R5 xfer_busy", int'(xfer_busy), f_busy());
            chk("R6 xfer_done", int'(xfer_done), f_irq());
            chk("R4 ser_doe", int'(ser_doe), f_oe());
            chk("R4 ser_dout", int'(ser_dout), f_sdo());
            chk("R3 rdata", int'(rdata), f_rdata());
            chk("R9 rdy_tmo_err", int'(rdy_tmo_err), f_err());
        end
        if (ser_clk && !prev_clk) pulses++;
        prev_clk = ser_clk;
        if (m_started && m_rd) begin
            k = m_e / (2 * m_h);
            ser_din <= (k < m_n) ? ((m_rbyte >> (7 - k)) & 1) != 0 : 1'b0;
        end else if (m_started && m_wf) begin
            ser_din <= (m_e >= f_tend() + m_rdy);
        end else begin
            ser_din <= 1'b0;
        end
    end

    task automatic put_data(input int v);
        @(negedge clk); data_in = DW'(v); data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic put_ctl(input int b, input int div);
        @(negedge clk); ctl_byte = 8'(b); half_div = DIVW'(div); ctl_we = 1'b1;
        pulses = 0;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (f_busy() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12: load while idle
        put_data(8'hA5);
        @(negedge clk);
        chk("R12 load visible", int'(rdata), 8'hA5);

        // R1 R4: write 8 bits, hold low afterwards
        put_ctl(8'h08, 1);
        wait_idle();
        chk("R1 pulse count", pulses, 8);
        chk("R4 held low", int'(ser_doe), 1);

        // R4: write 6 bits with release, fastest divider
        put_data(8'h6C);
        put_ctl(8'h26, 0);
        wait_idle();
        chk("R2 six pulses", pulses, 6);
        chk("R4 released", int'(ser_doe), 0);

        // R3: full read
        tb_rbyte = 8'h3C;
        put_ctl(8'h18, 2);
        wait_idle();
        chk("R3 read byte", int'(rdata), 8'h3C);

        // R3: partial read of 5 bits
        put_data(8'hFF);
        tb_rbyte = 8'h52;
        put_ctl(8'h15, 1);
        wait_idle();
        chk("R3 partial read", int'(rdata), 8'hEA);

        // R7: count zero drives low, then releases
        put_ctl(8'h00, 0);
        repeat (2) @(negedge clk);
        chk("R7 zero count drives", int'(ser_doe), 1);
        chk("R7 zero count no pulse", pulses, 0);
        put_ctl(8'h30, 0);
        repeat (2) @(negedge clk);
        chk("R7 zero count releases", int'(ser_doe), 0);

        // R10: writes during a transfer are ignored
        put_data(8'h81);
        put_ctl(8'h04, 3);
        repeat (3) @(negedge clk);
        put_ctl(8'h08, 0);
        put_data(8'h00);
        pulses = pulses;
        wait_idle();
        chk("R10 ignored rdata", int'(rdata), 8'h10);

        // R11: count 12 behaves as 8
        put_data(8'hC3);
        put_ctl(8'h0C, 0);
        wait_idle();
        chk("R11 clamp", pulses, 8);

        // R8: ready after a few cycles
        put_data(8'h9A);
        tb_rdy = 5;
        put_ctl(8'h68, 1);
        wait_idle();
        chk("R8 no error", int'(rdy_tmo_err), 0);

        // R8: wait bit without release does not wait
        tb_rdy = 1000;
        put_ctl(8'h48, 0);
        wait_idle();
        chk("R8 no wait without release", int'(ser_doe), 1);

        // R9: timeout, then cleared by next control byte
        put_ctl(8'h63, 0);
        wait_idle();
        chk("R9 timeout flag", int'(rdy_tmo_err), 1);
        put_ctl(8'h20, 0);
        repeat (2) @(negedge clk);
        chk("R9 flag cleared", int'(rdy_tmo_err), 0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule